// File: doc/BRIEF.md
# Slow-Clock Tick Counter with Match Interrupt

This block keeps a free-running 32-bit count that advances from a low-frequency oscillator clock (nominally 32.768 kHz), while software reaches it through a small register file on a fast bus clock. A prescaler lets each count step cover one or more oscillator edges. A compare register raises a sticky interrupt when the count steps onto the programmed value. It is used as a wall-clock source and as a one-shot event timer that keeps running while the fast clock domain sleeps.

Every write that has to reach the oscillator domain is tracked by its own busy flag, which stays set until the slow side has taken the value. A write to a register whose busy flag is set is dropped. The count comes back to the bus side through a hold-and-acknowledge loop, so a read never mixes bits from two different counts. An oscillator-detected flag lets software confirm that the slow clock has ever run.

Register offsets on `addr`: 0 control/status, 1 trim, 2 preload, 3 count, 4 match. Control/status bits: 0 enable (read/write), 1 oscillator seen, 2 trim busy, 3 preload busy, 4 match busy, and 5 match flag (write one to clear).

Top module: `slt_timer`

## Requirements
- R1: The count is 32 bits wide. It increments by one per tick and wraps from 0xFFFFFFFF to 0 without stopping.
- R2: With trim value t (offset 1), the count advances once every t+1 oscillator edges. A trim of 0 advances it on every oscillator edge.
- R3: The count advances only while control bit 0 is set. Clearing bit 0 freezes the count. Bit 0 reads back the value last written to it.
- R4: Control bit 1 reads 0 after reset until the oscillator has produced an edge. From then on it stays 1, even if the oscillator stops.
- R5: A write to offset 1 sets control bit 2 until the slow domain has taken the new trim value. Offset 1 reads back the accepted trim value.
- R6: A write to offset 2 loads the count and sets control bit 3 until the load has happened. Offset 2 reads back the accepted preload value.
- R7: A write to offset 4 sets control bit 4 until the slow domain has taken it. Any write to offsets 1, 2 or 4 while that register's busy bit is set is ignored, and readback shows the earlier value.
- R8: A read of offset 3 returns a coherent 32-bit count as sampled from the slow domain. After reset it reads 0.
- R9: When the count steps onto the match value (offset 4), control bit 5 and the `irq` output go high. They stay high until a write to offset 0 with bit 5 set. A match value behind the count does not fire, and one 8 ticks ahead does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast register-interface clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| osc_clk | input | 1 | Low-frequency oscillator clock |
| we | input | 1 | Register write strobe |
| re | input | 1 | Register read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read data valid, one cycle after `re` |
| irq | output | 1 | Sticky match interrupt |

## Verification
The bench loads a count just below the all-ones boundary and lets it run across the wrap. A design that saturated or stalled there would read back near 0xFFFFFFFF instead of a small value, and would miss the match placed just past zero. It issues two match writes back to back: if a write during a pending crossing were not dropped, the readback would show the second value. It stops the oscillator after it has run, to catch a detected flag that follows the live clock, and it counts across a long window with trims of 0 and 3 so that an off-by-one divider lands outside the accepted band. It also sets one match value behind the count and one exactly 8 ticks ahead, to expose a comparator that fires on stale values or misses a near event.

// File: rtl/slt_pkg.sv
`timescale 1ns/1ps
package slt_pkg;
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] OFS_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] OFS_TRIM  = 3'd1;
   localparam logic [ADDR_W-1:0] OFS_LOAD  = 3'd2;
   localparam logic [ADDR_W-1:0] OFS_COUNT = 3'd3;
   localparam logic [ADDR_W-1:0] OFS_MATCH = 3'd4;
   localparam int BIT_EN    = 0;
   localparam int BIT_OSC   = 1;
   localparam int BIT_TBUSY = 2;
   localparam int BIT_LBUSY = 3;
   localparam int BIT_MBUSY = 4;
   localparam int BIT_FLAG  = 5;
endpackage

// File: rtl/slt_wr_xfer.sv
`timescale 1ns/1ps
module slt_wr_xfer #(
   parameter int W = 32
) (
   input  logic         bclk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] hold,
   output logic         busy,
   input  logic         sclk,
   output logic [W-1:0] sdata,
   output logic         upd
);
   logic       req, ack, seen;
   logic [1:0] ack_sy, req_sy;
   logic       take;

   assign busy = req ^ ack_sy[1];
   assign take = req_sy[1] ^ seen;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         hold   <= '0;
         req    <= 1'b0;
         ack_sy <= '0;
      end else begin
         ack_sy <= {ack_sy[0], ack};
         if (wr && !busy) begin
            hold <= wdata;
            req  <= ~req;
         end
      end
   end

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         req_sy <= '0;
         seen   <= 1'b0;
         ack    <= 1'b0;
         sdata  <= '0;
         upd    <= 1'b0;
      end else begin
         req_sy <= {req_sy[0], req};
         upd    <= take;
         ack    <= seen;
         if (take) begin
            sdata <= hold;
            seen  <= req_sy[1];
         end
      end
   end

   // R5
   busy_set_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      (wr && !busy) |=> busy);
   // R7
   hold_kept_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      (wr && busy) |=> $stable(hold));
endmodule

// File: rtl/slt_count_xfer.sv
`timescale 1ns/1ps
module slt_count_xfer #(
   parameter int W = 32
) (
   input  logic         sclk,
   input  logic         rst_n,
   input  logic [W-1:0] count,
   input  logic         bclk,
   output logic [W-1:0] bcount
);
   logic [W-1:0] snap;
   logic         stgl, back;
   logic [1:0]   back_sy, fwd_sy;

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         snap    <= '0;
         stgl    <= 1'b0;
         back_sy <= '0;
      end else begin
         back_sy <= {back_sy[0], back};
         if (back_sy[1] == stgl) begin
            snap <= count;
            stgl <= ~stgl;
         end
      end
   end

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         bcount <= '0;
         back   <= 1'b0;
         fwd_sy <= '0;
      end else begin
         fwd_sy <= {fwd_sy[0], stgl};
         if (fwd_sy[1] != back) begin
            bcount <= snap;
            back   <= fwd_sy[1];
         end
      end
   end

   // R8
   snap_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
      (back_sy[1] != stgl) |=> $stable(snap));
endmodule

// File: rtl/slt_core.sv
`timescale 1ns/1ps
module slt_core #(
   parameter int CNT_W    = 32,
   parameter int TRIM_W   = 16,
   parameter bit PRESCALE = 1'b1
) (
   input  logic              sclk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [TRIM_W-1:0] trim,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_val,
   input  logic [CNT_W-1:0]  match,
   output logic [CNT_W-1:0]  count,
   output logic              evt_tgl
);
   logic             tick;
   logic [CNT_W-1:0] nxt;

   assign nxt = count + 1'b1;

   generate
      if (PRESCALE) begin : g_div
         logic [TRIM_W-1:0] pcnt;
         assign tick = en && (pcnt == '0);
         always_ff @(posedge sclk or negedge rst_n) begin
            if (!rst_n)               pcnt <= '0;
            else if (load)            pcnt <= trim;
            else if (en)              pcnt <= (pcnt == '0) ? trim : pcnt - 1'b1;
         end
      end else begin : g_nodiv
         assign tick = en;
      end
   endgenerate

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         evt_tgl <= 1'b0;
      end else begin
         if (load)      count <= load_val;
         else if (tick) count <= nxt;
         if (!load && tick && (nxt == match)) evt_tgl <= ~evt_tgl;
      end
   end

   // R1
   advance_chk: assert property (@(posedge sclk) disable iff (!rst_n)
      (tick && !load) |=> (count == CNT_W'($past(count) + 1'b1)));
   // R3
   freeze_chk: assert property (@(posedge sclk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(count));
endmodule

// File: rtl/slt_timer.sv
`timescale 1ns/1ps
module slt_timer
   import slt_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 32,
   parameter int TRIM_W   = 16,
   parameter bit PRESCALE = 1'b1,
   parameter int SYNC_N   = 2
) (
   input  logic              bus_clk,
   input  logic              rst_n,
   input  logic              osc_clk,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid,
   output logic              irq
);
   localparam int FLAG_MSB = BIT_FLAG;

   generate
      if (CNT_W < 8 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie between 8 and DATA_W");
      end
      if (TRIM_W < 1 || TRIM_W > DATA_W) begin : g_bad_trim
         $error("TRIM_W must lie between 1 and DATA_W");
      end
      if (SYNC_N < 2 || DATA_W <= FLAG_MSB) begin : g_bad_sync
         $error("SYNC_N must be at least 2 and DATA_W must hold the status bits");
      end
   endgenerate

   logic              en_b, flag_b, osc_b;
   logic [SYNC_N-1:0] en_sy, osc_sy;
   logic [SYNC_N:0]   evt_sy;
   logic              seen_s, evt_tgl, evt_pls, flag_clr;
   logic              t_busy, l_busy, m_busy, t_upd, l_upd, m_upd;
   logic [TRIM_W-1:0] t_hold, t_s;
   logic [CNT_W-1:0]  l_hold, l_s, m_hold, m_s, cnt_s, cnt_b;
   logic [DATA_W-1:0] status;

   slt_wr_xfer #(.W(TRIM_W)) u_trim (
      .bclk(bus_clk), .rst_n(rst_n), .wr(we && addr == OFS_TRIM),
      .wdata(wdata[TRIM_W-1:0]), .hold(t_hold), .busy(t_busy),
      .sclk(osc_clk), .sdata(t_s), .upd(t_upd));
   slt_wr_xfer #(.W(CNT_W)) u_load (
      .bclk(bus_clk), .rst_n(rst_n), .wr(we && addr == OFS_LOAD),
      .wdata(wdata[CNT_W-1:0]), .hold(l_hold), .busy(l_busy),
      .sclk(osc_clk), .sdata(l_s), .upd(l_upd));
   slt_wr_xfer #(.W(CNT_W)) u_match (
      .bclk(bus_clk), .rst_n(rst_n), .wr(we && addr == OFS_MATCH),
      .wdata(wdata[CNT_W-1:0]), .hold(m_hold), .busy(m_busy),
      .sclk(osc_clk), .sdata(m_s), .upd(m_upd));

   slt_core #(.CNT_W(CNT_W), .TRIM_W(TRIM_W), .PRESCALE(PRESCALE)) u_core (
      .sclk(osc_clk), .rst_n(rst_n), .en(en_sy[SYNC_N-1]), .trim(t_s),
      .load(l_upd), .load_val(l_s), .match(m_s), .count(cnt_s),
      .evt_tgl(evt_tgl));

   slt_count_xfer #(.W(CNT_W)) u_cnt (
      .sclk(osc_clk), .rst_n(rst_n), .count(cnt_s), .bclk(bus_clk),
      .bcount(cnt_b));

   // slow domain: enable synchroniser and oscillator-seen latch
   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         en_sy  <= '0;
         seen_s <= 1'b0;
      end else begin
         en_sy  <= {en_sy[SYNC_N-2:0], en_b};
         seen_s <= 1'b1;
      end
   end

   assign evt_pls  = evt_sy[SYNC_N] ^ evt_sy[SYNC_N-1];
   assign flag_clr = we && (addr == OFS_CTRL) && wdata[BIT_FLAG];
   assign osc_b    = osc_sy[SYNC_N-1];
   assign irq      = flag_b;

   always_comb begin
      status            = '0;
      status[BIT_EN]    = en_b;
      status[BIT_OSC]   = osc_b;
      status[BIT_TBUSY] = t_busy;
      status[BIT_LBUSY] = l_busy;
      status[BIT_MBUSY] = m_busy;
      status[BIT_FLAG]  = flag_b;
   end

   always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n) begin
         en_b   <= 1'b0;
         flag_b <= 1'b0;
         osc_sy <= '0;
         evt_sy <= '0;
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         osc_sy <= {osc_sy[SYNC_N-2:0], seen_s};
         evt_sy <= {evt_sy[SYNC_N-1:0], evt_tgl};
         if (we && addr == OFS_CTRL) en_b <= wdata[BIT_EN];
         if (evt_pls)       flag_b <= 1'b1;
         else if (flag_clr) flag_b <= 1'b0;
         rvalid <= re;
         if (re) begin
            case (addr)
               OFS_CTRL:  rdata <= status;
               OFS_TRIM:  rdata <= DATA_W'(t_hold);
               OFS_LOAD:  rdata <= DATA_W'(l_hold);
               OFS_COUNT: rdata <= DATA_W'(cnt_b);
               OFS_MATCH: rdata <= DATA_W'(m_hold);
               default:   rdata <= '0;
            endcase
         end
      end
   end

   // R4
   osc_keep_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
      osc_b |=> osc_b);
   // R9
   flag_sticky_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (flag_b && !flag_clr) |=> flag_b);
   // R9
   flag_set_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
      evt_pls |=> irq);
endmodule

// File: tb/slt_timer_test.sv
`timescale 1ns/1ps
module slt_timer_test;
   localparam int CLK_PERIOD = 10;
   localparam int OSC_HALF   = 17;

   logic        bus_clk = 1'b0, osc_clk = 1'b0, osc_run = 1'b0;
   logic        rst_n = 1'b0, we = 1'b0, re = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0, rdata;
   logic        rvalid, irq;

   int          n_chk = 0, n_fail = 0;
   logic [31:0] last_rd = '0;

   typedef struct {
      logic [31:0] mask;
      logic [31:0] lo;
      logic [31:0] hi;
      string       tag;
   } exp_t;
   exp_t sb[$];

   slt_timer uut (
      .bus_clk(bus_clk), .rst_n(rst_n), .osc_clk(osc_clk), .we(we), .re(re),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .irq(irq));

   always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
   always begin
      #(OSC_HALF);
      if (osc_run) osc_clk = ~osc_clk;
   end

   // monitor: compares each read result against the queued expectation
   always @(negedge bus_clk) begin
      if (rvalid) begin
         logic [31:0] v;
         last_rd = rdata;
         n_chk++;
         if (sb.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected read data actual %h expected none", rdata);
         end else begin
            exp_t e;
            e = sb.pop_front();
            v = rdata & e.mask;
            if (v < e.lo || v > e.hi) begin
               n_fail++;
               $display("FAIL %s actual %h expected %h..%h", e.tag, v, e.lo, e.hi);
            end
         end
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(posedge bus_clk);
      #1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(posedge bus_clk); #1;
      we = 1'b1; addr = a; wdata = d;
      @(posedge bus_clk); #1;
      we = 1'b0;
   endtask

   task automatic rd_exp(input logic [2:0] a, input logic [31:0] m,
                         input logic [31:0] lo, input logic [31:0] hi,
                         input string tag);
      exp_t e;
      e.mask = m; e.lo = lo; e.hi = hi; e.tag = tag;
      @(posedge bus_clk); #1;
      re = 1'b1; addr = a;
      sb.push_back(e);
      @(posedge bus_clk); #1;
      re = 1'b0;
      wait_clk(2);
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      n_chk++;
      if (irq !== exp) begin
         n_fail++;
         $display("FAIL %s irq actual %b expected %b", tag, irq, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge bus_clk);
      n_fail++;
      $display("FAIL watchdog expired actual hung expected done");
      finish_run();
   end

   initial begin
      logic [31:0] frozen;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);
      // reset state
      rd_exp(3'd0, 32'hFFFF_FFFF, 32'h0, 32'h0, "R4 reset status");
      rd_exp(3'd3, 32'hFFFF_FFFF, 32'h0, 32'h0, "R8 reset count");
      chk_irq(1'b0, "R9 reset");

      // oscillator detect, then stop it
      osc_run = 1'b1;
      wait_clk(30);
      rd_exp(3'd0, 32'h2, 32'h2, 32'h2, "R4 osc seen");
      osc_run = 1'b0;
      wait_clk(40);
      rd_exp(3'd0, 32'h2, 32'h2, 32'h2, "R4 osc seen after stop");
      osc_run = 1'b1;
      wait_clk(10);

      // trim write busy
      wr(3'd1, 32'h0);
      rd_exp(3'd0, 32'h4, 32'h4, 32'h4, "R5 trim busy set");
      wait_clk(40);
      rd_exp(3'd0, 32'h4, 32'h0, 32'h0, "R5 trim busy clear");
      rd_exp(3'd1, 32'hFFFF_FFFF, 32'h0, 32'h0, "R5 trim readback");

      // preload with counting disabled
      wr(3'd2, 32'h1234_5678);
      rd_exp(3'd0, 32'h8, 32'h8, 32'h8, "R6 load busy set");
      wait_clk(60);
      rd_exp(3'd0, 32'h8, 32'h0, 32'h0, "R6 load busy clear");
      rd_exp(3'd3, 32'hFFFF_FFFF, 32'h1234_5678, 32'h1234_5678, "R6 R8 loaded count");
      rd_exp(3'd2, 32'hFFFF_FFFF, 32'h1234_5678, 32'h1234_5678, "R6 preload readback");

      // back-to-back match writes: second one dropped
      wr(3'd4, 32'h10);
      wr(3'd4, 32'h20);
      rd_exp(3'd0, 32'h10, 32'h10, 32'h10, "R7 match busy set");
      rd_exp(3'd4, 32'hFFFF_FFFF, 32'h10, 32'h10, "R7 write while busy ignored");
      wait_clk(40);
      rd_exp(3'd0, 32'h10, 32'h0, 32'h0, "R7 match busy clear");

      // wrap across all-ones, passing the match at 0x10
      wr(3'd2, 32'hFFFF_FFFA);
      wait_clk(40);
      wr(3'd0, 32'h1);
      rd_exp(3'd0, 32'h1, 32'h1, 32'h1, "R3 enable readback");
      wait_clk(150);
      wr(3'd0, 32'h0);
      wait_clk(60);
      rd_exp(3'd3, 32'hFFFF_FFFF, 32'h10, 32'h40, "R1 count wrapped");
      frozen = last_rd;
      chk_irq(1'b1, "R9 match after wrap");
      rd_exp(3'd0, 32'h20, 32'h20, 32'h20, "R9 flag bit set");
      wait_clk(100);
      rd_exp(3'd3, 32'hFFFF_FFFF, frozen, frozen, "R3 count frozen while disabled");
      wr(3'd0, 32'h20);
      wait_clk(2);
      chk_irq(1'b0, "R9 write one clears");

      // full-rate count over a long window
      wr(3'd4, 32'hFFFF_0000);
      wr(3'd2, 32'h0);
      wait_clk(40);
      wr(3'd0, 32'h1);
      wait_clk(400);
      wr(3'd0, 32'h0);
      wait_clk(60);
      rd_exp(3'd3, 32'hFFFF_FFFF, 32'd112, 32'd123, "R2 trim 0 rate");

      // divided rate
      wr(3'd1, 32'h3);
      wait_clk(40);
      wr(3'd2, 32'h0);
      wait_clk(40);
      rd_exp(3'd1, 32'hFFFF_FFFF, 32'h3, 32'h3, "R5 trim readback 3");
      wr(3'd0, 32'h1);
      wait_clk(400);
      wr(3'd0, 32'h0);
      wait_clk(60);
      rd_exp(3'd3, 32'hFFFF_FFFF, 32'd26, 32'd33, "R2 trim 3 rate");

      // match behind the count never fires
      wr(3'd1, 32'h0);
      wr(3'd2, 32'd1000);
      wr(3'd4, 32'd500);
      wait_clk(40);
      wr(3'd0, 32'h20);
      wait_clk(2);
      wr(3'd0, 32'h1);
      wait_clk(100);
      wr(3'd0, 32'h0);
      wait_clk(60);
      chk_irq(1'b0, "R9 match behind count");

      // match exactly 8 ticks ahead
      wr(3'd2, 32'd2000);
      wr(3'd4, 32'd2008);
      wait_clk(40);
      wr(3'd0, 32'h1);
      wait_clk(100);
      wr(3'd0, 32'h0);
      wait_clk(60);
      chk_irq(1'b1, "R9 match 8 ahead");

      wait_clk(5);
      finish_run();
   end
endmodule